// File: doc/BRIEF.md
# Three-Bus Register-Transfer Datapath

This block executes the register-to-register operations of an 18-bit processor. Each operation carries three independent 3-bit selection fields. One picks the source driven onto the A bus, one picks the source on the B bus, and one picks the set of registers written from the result (S) bus. A combinational unit adds, subtracts, ANDs or ORs the two buses. Data words are sign-magnitude: bit 17 is the sign and bits 16:0 are the magnitude. The block holds two accumulators, two index registers, a program counter, a 6-bit shift counter and a 12-bit trace register. It also reads an 18-bit console-switch input.

Because the three fields are independent, several operations need no dedicated opcode. Clear selects zero on both buses. Compare selects no destination and reports zero and negative flags. Exchange uses a direct path that copies accumulator 1 into accumulator 2. Jump writes the result to the program counter. An immediate mode reuses the six bits of the B and A fields as an unsigned constant from 0 to 63. The other operand is then the current value of the destination register, which also gives relative jumps.

Top module: `tribus_datapath`

## Requirements
- R1: While rst_n is low, every register and all three compare outputs (cmp_valid, cmp_zero, cmp_neg) are zero.
- R2: With op_imm low, op_a selects the A operand: 000 zero, 001 accumulator 1, 010 accumulator 2, 011 index 1, 100 index 2, 101 program counter; 110 and 111 read as zero.
- R3: With op_imm low, op_b selects the B operand: 000 zero, 001 accumulator 1, 010 {trace, shift counter} with trace in bits 17:6, 011 shift counter zero-extended, 100 switches; 101, 110 and 111 read as zero.
- R4: op_s selects the destinations, written on the rising edge at which op_valid is high: 000 none, 001 accumulator 1, 010 accumulator 2, 011 both accumulators, 100 index 1, 101 index 2, 110 shift counter, 111 program counter. With op_valid low no register changes.
- R5: op_fn 00 adds and 01 subtracts in sign-magnitude. Subtract negates B by flipping its sign bit. The result magnitude wraps modulo 2^17, and a zero magnitude always gets sign 0.
- R6: op_fn 10 is bitwise AND and 11 is bitwise OR of all 18 bits. When op_inv is high, the sign bit of the B operand is flipped before any function is applied.
- R7: With op_imm high, the B operand is the unsigned value {op_b, op_a}. The A operand is the current value of the register selected by op_s, or accumulator 1 when op_s is 000 or 011. The shift counter is zero-extended.
- R8: An op with op_s = 000 writes no register except through the direct path of R9. In the following cycle only, cmp_valid is 1, cmp_zero is 1 when the result magnitude is 0, and cmp_neg is 1 when the result sign is 1 and the magnitude is nonzero. In every other cycle all three are 0.
- R9: With op_imm low and op_b = 101, accumulator 2 is loaded with the pre-edge value of accumulator 1. This takes priority over any S write to accumulator 2, and the B operand is zero.
- R10: op_s = 111 loads the program counter from the result and loads trace with the old program counter bits 11:0. Every other valid op increments the program counter by 1 modulo 2^18.
- R11: A write to the shift counter takes result bits 5:0.
- R12: With op_a = 000, op_b = 000 and add, every selected destination is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Execute the presented operation at this edge |
| op_imm | input | 1 | Immediate mode |
| op_fn | input | 2 | Function: add, subtract, AND, OR |
| op_inv | input | 1 | Flip sign bit of B operand |
| op_s | input | 3 | Destination select |
| op_b | input | 3 | B source select / high constant bits |
| op_a | input | 3 | A source select / low constant bits |
| switches | input | 18 | Console switch word |
| ac1 | output | 18 | Accumulator 1 |
| ac2 | output | 18 | Accumulator 2 |
| ix1 | output | 18 | Index register 1 |
| ix2 | output | 18 | Index register 2 |
| pc | output | 18 | Program counter |
| sc | output | 6 | Shift counter |
| trace | output | 12 | Trace register |
| cmp_valid | output | 1 | Compare result present |
| cmp_zero | output | 1 | Compare result was zero |
| cmp_neg | output | 1 | Compare result was negative |

## Verification
Every register result, including the direct-path copy and the trace capture, appears one rising edge after the operation is presented. The compare flags appear in that same following cycle and last for that cycle only. The bench drives each operation on a falling edge and samples every output at the next falling edge. At that point the behavioural model has also taken exactly one step, so each register and flag is checked in the cycle it is due. Idle cycles with op_valid low are checked the same way, which confirms that nothing moves and that the flags return to zero.

// File: rtl/tribus_datapath.sv
module tribus_datapath #(
  parameter int W   = 18,
  parameter int SCW = 6,
  parameter int FW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic           op_imm,
  input  logic [1:0]     op_fn,
  input  logic           op_inv,
  input  logic [FW-1:0]  op_s,
  input  logic [FW-1:0]  op_b,
  input  logic [FW-1:0]  op_a,
  input  logic [W-1:0]   switches,
  output logic [W-1:0]   ac1,
  output logic [W-1:0]   ac2,
  output logic [W-1:0]   ix1,
  output logic [W-1:0]   ix2,
  output logic [W-1:0]   pc,
  output logic [SCW-1:0] sc,
  output logic [W-SCW-1:0] trace,
  output logic           cmp_valid,
  output logic           cmp_zero,
  output logic           cmp_neg
);
  localparam int MW = W - 1;
  localparam int TW = W - SCW;
  localparam int IW = 2 * FW;

  localparam logic [FW-1:0] A_AC1 = FW'(1), A_AC2 = FW'(2), A_IX1 = FW'(3),
                            A_IX2 = FW'(4), A_PC  = FW'(5);
  localparam logic [FW-1:0] B_AC1 = FW'(1), B_TSC = FW'(2), B_SC  = FW'(3),
                            B_SW  = FW'(4), B_DIR = FW'(5);
  localparam logic [FW-1:0] S_NONE = FW'(0), S_AC1 = FW'(1), S_AC2 = FW'(2),
                            S_BOTH = FW'(3), S_IX1 = FW'(4), S_IX2 = FW'(5),
                            S_SC   = FW'(6), S_PC  = FW'(7);
  localparam logic [1:0] FN_ADD = 2'd0, FN_SUB = 2'd1, FN_AND = 2'd2, FN_OR = 2'd3;

  logic [W-1:0] a_bus, b_raw, b_op, s_bus, arith;
  logic [MW-1:0] mag_sum, mag_dif, mag;
  logic a_ge, same, sgn, flip, direct, is_cmp;

  always_comb begin
    if (op_imm) begin
      case (op_s)
        S_AC2:   a_bus = ac2;
        S_IX1:   a_bus = ix1;
        S_IX2:   a_bus = ix2;
        S_SC:    a_bus = W'(sc);
        S_PC:    a_bus = pc;
        default: a_bus = ac1;
      endcase
    end else begin
      case (op_a)
        A_AC1:   a_bus = ac1;
        A_AC2:   a_bus = ac2;
        A_IX1:   a_bus = ix1;
        A_IX2:   a_bus = ix2;
        A_PC:    a_bus = pc;
        default: a_bus = '0;
      endcase
    end
  end

  always_comb begin
    if (op_imm) b_raw = {{(W-IW){1'b0}}, op_b, op_a};
    else begin
      case (op_b)
        B_AC1:   b_raw = ac1;
        B_TSC:   b_raw = {trace, sc};
        B_SC:    b_raw = W'(sc);
        B_SW:    b_raw = switches;
        default: b_raw = '0;
      endcase
    end
  end

  assign flip    = op_inv ^ (op_fn == FN_SUB);
  assign b_op    = {b_raw[W-1] ^ flip, b_raw[MW-1:0]};
  assign same    = a_bus[W-1] == b_op[W-1];
  assign a_ge    = a_bus[MW-1:0] >= b_op[MW-1:0];
  assign mag_sum = a_bus[MW-1:0] + b_op[MW-1:0];
  assign mag_dif = a_ge ? a_bus[MW-1:0] - b_op[MW-1:0] : b_op[MW-1:0] - a_bus[MW-1:0];
  assign mag     = same ? mag_sum : mag_dif;
  assign sgn     = (same || a_ge) ? a_bus[W-1] : b_op[W-1];
  assign arith   = {sgn & (|mag), mag};

  always_comb begin
    case (op_fn)
      FN_AND:  s_bus = a_bus & b_op;
      FN_OR:   s_bus = a_bus | b_op;
      default: s_bus = arith;
    endcase
  end

  assign direct = !op_imm && (op_b == B_DIR);
  assign is_cmp = op_valid && (op_s == S_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac1 <= '0; ac2 <= '0; ix1 <= '0; ix2 <= '0; pc <= '0;
      sc <= '0; trace <= '0;
      cmp_valid <= 1'b0; cmp_zero <= 1'b0; cmp_neg <= 1'b0;
    end else begin
      cmp_valid <= is_cmp;
      cmp_zero  <= is_cmp && ~|s_bus[MW-1:0];
      cmp_neg   <= is_cmp && s_bus[W-1] && |s_bus[MW-1:0];
      if (op_valid) begin
        if (op_s == S_AC1 || op_s == S_BOTH) ac1 <= s_bus;
        if (direct) ac2 <= ac1;
        else if (op_s == S_AC2 || op_s == S_BOTH) ac2 <= s_bus;
        if (op_s == S_IX1) ix1 <= s_bus;
        if (op_s == S_IX2) ix2 <= s_bus;
        if (op_s == S_SC)  sc  <= s_bus[SCW-1:0];
        if (op_s == S_PC) begin
          pc    <= s_bus;
          trace <= pc[TW-1:0];
        end else begin
          pc <= pc + W'(1);
        end
      end
    end
  end
endmodule

module tribus_datapath_chk #(
  parameter int W   = 18,
  parameter int SCW = 6,
  parameter int FW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           op_valid,
  input logic           op_imm,
  input logic [FW-1:0]  op_s,
  input logic [FW-1:0]  op_b,
  input logic [W-1:0]   ac1,
  input logic [W-1:0]   ac2,
  input logic [W-1:0]   ix1,
  input logic [W-1:0]   ix2,
  input logic [W-1:0]   pc,
  input logic [SCW-1:0] sc,
  input logic           cmp_valid,
  input logic           cmp_zero,
  input logic           cmp_neg
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(ac1) && $stable(ac2) && $stable(ix1) && $stable(ix2) && $stable(pc) && $stable(sc))); // R4
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_s == '0 && (op_imm || op_b != FW'(5))) |=>
      ($stable(ac1) && $stable(ac2) && $stable(ix1) && $stable(ix2) && $stable(sc))); // R8
  AST_CMP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_s == '0) |=> cmp_valid); // R8
  AST_FLAGS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |-> (!cmp_zero && !cmp_neg)); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_zero && cmp_neg)); // R8
  AST_DIRECT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_imm && op_b == FW'(5)) |=> (ac2 == $past(ac1))); // R9
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_s != FW'(7)) |=> (pc == $past(pc) + W'(1))); // R10
endmodule

bind tribus_datapath tribus_datapath_chk #(.W(W), .SCW(SCW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_imm(op_imm),
  .op_s(op_s), .op_b(op_b), .ac1(ac1), .ac2(ac2), .ix1(ix1), .ix2(ix2),
  .pc(pc), .sc(sc), .cmp_valid(cmp_valid), .cmp_zero(cmp_zero), .cmp_neg(cmp_neg)
);

// File: tb/tribus_datapath_tb_top.sv
module tribus_datapath_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, op_imm = 1'b0, op_inv = 1'b0;
  logic [1:0] op_fn = 2'd0;
  logic [2:0] op_s = 3'd0, op_b = 3'd0, op_a = 3'd0;
  logic [17:0] switches = 18'd0;
  logic [17:0] ac1, ac2, ix1, ix2, pc;
  logic [5:0] sc;
  logic [11:0] trace;
  logic cmp_valid, cmp_zero, cmp_neg;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [17:0] e_ac1 = 0, e_ac2 = 0, e_ix1 = 0, e_ix2 = 0, e_pc = 0;
  logic [5:0]  e_sc = 0;
  logic [11:0] e_tr = 0;
  logic e_cv = 0, e_cz = 0, e_cn = 0;

  always #10 clk = ~clk;

  tribus_datapath dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_imm(op_imm), .op_fn(op_fn),
    .op_inv(op_inv), .op_s(op_s), .op_b(op_b), .op_a(op_a), .switches(switches),
    .ac1(ac1), .ac2(ac2), .ix1(ix1), .ix2(ix2), .pc(pc), .sc(sc), .trace(trace),
    .cmp_valid(cmp_valid), .cmp_zero(cmp_zero), .cmp_neg(cmp_neg)
  );

  task automatic chk(input string tag, input string what, input logic [17:0] act, input logic [17:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [17:0] model_alu(input logic [17:0] a, input logic [17:0] b,
                                            input logic [1:0] fn, input logic inv);
    logic [17:0] bb;
    int va, vb, r, m;
    bb = b;
    if (inv) bb[17] = ~bb[17];
    if (fn == 2'd2) return a & bb;
    if (fn == 2'd3) return a | bb;
    if (fn == 2'd1) bb[17] = ~bb[17];
    va = a[17]  ? -int'(a[16:0])  : int'(a[16:0]);
    vb = bb[17] ? -int'(bb[16:0]) : int'(bb[16:0]);
    r = va + vb;
    m = (r < 0 ? -r : r) % 131072;
    return {(r < 0) && (m != 0), 17'(m)};
  endfunction

  task automatic check_all(input string tag);
    chk(tag, "ac1", ac1, e_ac1);
    chk(tag, "ac2", ac2, e_ac2);
    chk(tag, "ix1", ix1, e_ix1);
    chk(tag, "ix2", ix2, e_ix2);
    chk(tag, "pc", pc, e_pc);
    chk(tag, "sc", 18'(sc), 18'(e_sc));
    chk(tag, "trace", 18'(trace), 18'(e_tr));
    chk(tag, "cmp_valid", 18'(cmp_valid), 18'(e_cv));
    chk(tag, "cmp_zero", 18'(cmp_zero), 18'(e_cz));
    chk(tag, "cmp_neg", 18'(cmp_neg), 18'(e_cn));
  endtask

  task automatic do_op(input logic v, input logic imm, input logic [1:0] fn, input logic inv,
                       input logic [2:0] s, input logic [2:0] b, input logic [2:0] a, input string tag);
    logic [17:0] ao, bo, res;
    logic [17:0] n_ac1, n_ac2, n_ix1, n_ix2, n_pc;
    logic [5:0] n_sc;
    logic [11:0] n_tr;
    if (imm) begin
      case (s)
        3'd2: ao = e_ac2;
        3'd4: ao = e_ix1;
        3'd5: ao = e_ix2;
        3'd6: ao = {12'd0, e_sc};
        3'd7: ao = e_pc;
        default: ao = e_ac1;
      endcase
      bo = {12'd0, b, a};
    end else begin
      case (a)
        3'd1: ao = e_ac1;
        3'd2: ao = e_ac2;
        3'd3: ao = e_ix1;
        3'd4: ao = e_ix2;
        3'd5: ao = e_pc;
        default: ao = 18'd0;
      endcase
      case (b)
        3'd1: bo = e_ac1;
        3'd2: bo = {e_tr, e_sc};
        3'd3: bo = {12'd0, e_sc};
        3'd4: bo = switches;
        default: bo = 18'd0;
      endcase
    end
    res = model_alu(ao, bo, fn, inv);
    n_ac1 = e_ac1; n_ac2 = e_ac2; n_ix1 = e_ix1; n_ix2 = e_ix2;
    n_pc = e_pc; n_sc = e_sc; n_tr = e_tr;
    if (v) begin
      if (s == 3'd1 || s == 3'd3) n_ac1 = res;
      if (s == 3'd2 || s == 3'd3) n_ac2 = res;
      if (!imm && b == 3'd5) n_ac2 = e_ac1;
      if (s == 3'd4) n_ix1 = res;
      if (s == 3'd5) n_ix2 = res;
      if (s == 3'd6) n_sc = res[5:0];
      if (s == 3'd7) begin n_pc = res; n_tr = e_pc[11:0]; end
      else n_pc = e_pc + 18'd1;
    end
    op_valid = v; op_imm = imm; op_fn = fn; op_inv = inv; op_s = s; op_b = b; op_a = a;
    @(posedge clk);
    @(negedge clk);
    e_ac1 = n_ac1; e_ac2 = n_ac2; e_ix1 = n_ix1; e_ix2 = n_ix2;
    e_pc = n_pc; e_sc = n_sc; e_tr = n_tr;
    e_cv = v && s == 3'd0;
    e_cz = e_cv && res[16:0] == 17'd0;
    e_cn = e_cv && res[17] && res[16:0] != 17'd0;
    check_all(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
    switches = 18'd9;
    do_op(1, 1, 2'd0, 0, 3'd1, 3'd0, 3'd5, "R7");
    chk("R7", "ac1 imm", ac1, 18'd5);
    do_op(1, 1, 2'd0, 0, 3'd4, 3'd7, 3'd7, "R7");
    chk("R7", "ix1 imm", ix1, 18'd63);
    do_op(1, 0, 2'd0, 0, 3'd2, 3'd0, 3'd1, "R2");
    chk("R2", "ac2 copy", ac2, 18'd5);
    do_op(1, 0, 2'd1, 0, 3'd5, 3'd4, 3'd1, "R5");
    chk("R5", "ix2 5-9", ix2, 18'h20004);
    do_op(1, 0, 2'd1, 0, 3'd0, 3'd4, 3'd1, "R8");
    chk("R8", "neg flag", 18'(cmp_neg), 18'd1);
    do_op(1, 0, 2'd1, 0, 3'd0, 3'd1, 3'd1, "R8");
    chk("R8", "zero flag", 18'(cmp_zero), 18'd1);
    do_op(1, 0, 2'd0, 0, 3'd1, 3'd0, 3'd4, "R2");
    do_op(1, 0, 2'd1, 0, 3'd4, 3'd1, 3'd1, "R5");
    chk("R5", "minus zero", ix1, 18'd0);
    do_op(1, 0, 2'd0, 0, 3'd1, 3'd5, 3'd2, "R9");
    chk("R9", "xchg ac1", ac1, 18'd5);
    chk("R9", "xchg ac2", ac2, 18'h20004);
    do_op(1, 0, 2'd0, 0, 3'd2, 3'd5, 3'd4, "R9");
    chk("R9", "direct wins", ac2, 18'd5);
    do_op(1, 1, 2'd0, 0, 3'd4, 3'd5, 3'd0, "R7");
    do_op(1, 0, 2'd0, 0, 3'd7, 3'd0, 3'd3, "R10");
    chk("R10", "jump pc", pc, 18'd40);
    do_op(1, 1, 2'd0, 0, 3'd6, 3'd0, 3'd3, "R11");
    do_op(1, 0, 2'd3, 0, 3'd5, 3'd2, 3'd0, "R3");
    do_op(1, 0, 2'd2, 0, 3'd1, 3'd4, 3'd1, "R6");
    chk("R6", "and", ac1, 18'd1);
    do_op(1, 0, 2'd3, 0, 3'd1, 3'd4, 3'd2, "R6");
    do_op(1, 0, 2'd3, 1, 3'd2, 3'd4, 3'd2, "R6");
    chk("R6", "or inv", ac2, 18'h2000D);
    switches = 18'h1FFFF;
    do_op(1, 0, 2'd0, 0, 3'd1, 3'd4, 3'd0, "R3");
    do_op(1, 0, 2'd0, 0, 3'd2, 3'd1, 3'd1, "R5");
    chk("R5", "wrap", ac2, 18'h1FFFE);
    do_op(1, 0, 2'd0, 0, 3'd3, 3'd0, 3'd0, "R12");
    chk("R12", "clear both", ac1 | ac2, 18'd0);
    switches = 18'h000C7;
    do_op(1, 0, 2'd0, 0, 3'd6, 3'd4, 3'd0, "R11");
    chk("R11", "sc low bits", 18'(sc), 18'd7);
    do_op(1, 1, 2'd0, 0, 3'd4, 3'd1, 3'd0, "R7");
    do_op(1, 0, 2'd3, 0, 3'd4, 3'd6, 3'd7, "R2");
    chk("R3", "unused codes", ix1, 18'd0);
    do_op(0, 0, 2'd0, 0, 3'd3, 3'd4, 3'd0, "R4");
    do_op(1, 1, 2'd1, 0, 3'd0, 3'd0, 3'd0, "R8");
    do_op(1, 1, 2'd0, 0, 3'd7, 3'd0, 3'd2, "R10");
    for (int i = 0; i < 600; i++) begin
      switches = 18'($urandom);
      do_op($urandom_range(0, 4) != 0, $urandom_range(0, 3) == 0, 2'($urandom),
            1'($urandom), 3'($urandom), 3'($urandom), 3'($urandom), "R4 random");
    end
    op_valid = 1'b0;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule